// File: doc/BRIEF.md
# Dual-Clock Pointer Reset Controller

This block produces the two pointer resets of a dual-clock FIFO. `wr_ptr_rst` belongs to the write clock domain and `rd_ptr_rst` belongs to the read clock domain. Each domain has an active-high reset input. A per-pointer source-mode code chooses what resets that pointer:

- its own domain's reset alone;
- the opposite domain's reset, carried across by a reset synchronizer;
- the logical OR of the two.

With the right codes, a single reset in either domain, or one reset wired to both inputs, clears both pointers.

There are two synchronizers, one for each crossing direction. Each is a small state machine clocked by the destination clock. Its states are:

- `SY_HOLD`: the source reset is present.
- `SY_COUNT`: counting destination edges after the source reset is released.
- `SY_DONE`: the crossed reset has been released.

Its transitions are:

- any state to `SY_HOLD`, asynchronously, when the source reset rises;
- `SY_HOLD` to `SY_COUNT` on the first destination edge after release;
- `SY_COUNT` to `SY_COUNT` while the count is short of the depth;
- `SY_COUNT` to `SY_DONE` on the edge that reaches the configured depth;
- `SY_DONE` to `SY_DONE` while the source reset stays low.

A registered output holds the crossed reset high in every state except `SY_DONE`. Each direction has a 2-bit depth code that selects 2 to 5 destination edges.

Top module: `rstc_ptr_reset_ctrl`

## Requirements
- R1: With `rd_src_mode` at 2'b00 or 2'b01, `rd_ptr_rst` equals `rd_rst_in` without a clock edge, and `wr_rst_in` has no effect on it.
- R2: With `wr_src_mode` at 2'b00 or 2'b01, `wr_ptr_rst` equals `wr_rst_in` without a clock edge, and `rd_rst_in` has no effect on it.
- R3: With `rd_src_mode` at 2'b10, `rd_ptr_rst` is high while `rd_rst_in` is high or while the write reset crossed into the read domain is high.
- R4: With `wr_src_mode` at 2'b10, `wr_ptr_rst` is high while `wr_rst_in` is high or while the read reset crossed into the write domain is high.
- R5: With `rd_src_mode` at 2'b11, `rd_ptr_rst` follows only the crossed write reset, and `rd_rst_in` is ignored.
- R6: With `wr_src_mode` at 2'b11, `wr_ptr_rst` follows only the crossed read reset, and `wr_rst_in` is ignored.
- R7: A crossed reset rises as soon as its source reset rises, with no destination clock edge needed. This is visible on a pointer reset whose mode bit 1 is set.
- R8: After `wr_rst_in` falls, the crossed write reset falls on exactly the N-th rising `rd_clk` edge, where N = 2 + `w2r_depth`. The codes 2'b00, 2'b01, 2'b10 and 2'b11 give 2, 3, 4 and 5 edges.
- R9: After `rd_rst_in` falls, the crossed read reset falls on exactly the N-th rising `wr_clk` edge, where N = 2 + `r2w_depth`, with the same encoding as R8.
- R10: Once released, a crossed reset stays low for as long as its source reset stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| rd_clk | input | 1 | Read-domain clock |
| wr_rst_in | input | 1 | Write-domain reset, active high |
| rd_rst_in | input | 1 | Read-domain reset, active high |
| wr_src_mode | input | 2 | Reset source code for the write pointer |
| rd_src_mode | input | 2 | Reset source code for the read pointer |
| w2r_depth | input | 2 | Depth code for the write-to-read synchronizer |
| r2w_depth | input | 2 | Depth code for the read-to-write synchronizer |
| wr_ptr_rst | output | 1 | Write-pointer reset |
| rd_ptr_rst | output | 1 | Read-pointer reset |

## Verification
The hardest situation to reach is the release edge of a crossed reset. It must be shown to land on exactly the configured destination edge, and the crossed reset must be shown to rise between destination edges rather than on one.

The bench produces both situations with two unrelated clock periods, and the read clock is shifted by a fraction of a nanosecond. Every reset change then lands away from any edge of the other clock, and the bench probes the output a fraction of a nanosecond after a source reset rises. Each depth code is then swept with both pointers in cross-domain mode, and the bench counts destination edges from release until the pointer reset drops.

// File: rtl/rstc_pkg.sv
`timescale 1ns/1ps
package rstc_pkg;

    // Reset source selection for one pointer
    typedef enum logic [1:0] {
        SRC_OWN     = 2'b00,
        SRC_OWN_ALT = 2'b01,
        SRC_EITHER  = 2'b10,
        SRC_PEER    = 2'b11
    } src_mode_e;

    // Synchronizer release state machine
    typedef enum logic [1:0] {
        SY_HOLD  = 2'b00,
        SY_COUNT = 2'b01,
        SY_DONE  = 2'b10
    } sync_state_e;

    localparam int unsigned LANES = 2;
    localparam int unsigned LANE_RD = 0;
    localparam int unsigned LANE_WR = 1;

endpackage

// File: rtl/rstc_sync_fsm.sv
`timescale 1ns/1ps
// Crosses a reset into a destination clock: asserts at once, releases after a counted number of edges.
module rstc_sync_fsm
    import rstc_pkg::*;
#(
    parameter int unsigned CODE_W     = 2,
    parameter int unsigned MIN_STAGES = 2
) (
    input  logic              dst_clk,
    input  logic              src_rst,
    input  logic [CODE_W-1:0] depth_code,
    output logic              rst_out
);

    localparam int unsigned MAX_STAGES = MIN_STAGES + (1 << CODE_W) - 1;
    localparam int unsigned CNT_W      = $clog2(MAX_STAGES + 1);

    sync_state_e      state_q, state_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic [CNT_W-1:0] target;
    logic [CNT_W-1:0] cnt_inc;
    logic             rst_q;

    assign target  = CNT_W'(MIN_STAGES) + CNT_W'(depth_code);
    assign cnt_inc = cnt_q + CNT_W'(1);

    // State register
    always_ff @(posedge dst_clk or posedge src_rst) begin
        if (src_rst) begin
            state_q <= SY_HOLD;
            cnt_q   <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
        end
    end

    // Next-state logic
    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        unique case (state_q)
            SY_HOLD: begin
                cnt_n   = CNT_W'(1);
                state_n = (CNT_W'(1) >= target) ? SY_DONE : SY_COUNT;
            end
            SY_COUNT: begin
                if (cnt_inc >= target) begin
                    state_n = SY_DONE;
                end else begin
                    cnt_n = cnt_inc;
                end
            end
            SY_DONE: begin
                state_n = SY_DONE;
            end
            default: begin
                state_n = SY_HOLD;
                cnt_n   = '0;
            end
        endcase
    end

    // Output register: glitch-free reset toward the destination logic
    always_ff @(posedge dst_clk or posedge src_rst) begin
        if (src_rst) begin
            rst_q <= 1'b1;
        end else begin
            rst_q <= (state_n != SY_DONE);
        end
    end

    assign rst_out = rst_q;

endmodule

// File: rtl/rstc_src_sel.sv
`timescale 1ns/1ps
// Chooses the reset source of one pointer from its mode code.
module rstc_src_sel
    import rstc_pkg::*;
(
    input  logic [1:0] mode,
    input  logic       own_rst,
    input  logic       peer_sync,
    output logic       ptr_rst
);

    src_mode_e sel;

    assign sel = src_mode_e'(mode);

    always_comb begin
        unique case (sel)
            SRC_OWN, SRC_OWN_ALT: ptr_rst = own_rst;
            SRC_EITHER:           ptr_rst = own_rst | peer_sync;
            SRC_PEER:             ptr_rst = peer_sync;
            default:              ptr_rst = own_rst;
        endcase
    end

endmodule

// File: rtl/rstc_ptr_reset_ctrl.sv
`timescale 1ns/1ps
// Pointer reset generation for a dual-clock FIFO.
module rstc_ptr_reset_ctrl
    import rstc_pkg::*;
#(
    parameter int unsigned CODE_W     = 2,
    parameter int unsigned MIN_STAGES = 2
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              wr_rst_in,
    input  logic              rd_rst_in,
    input  logic [1:0]        wr_src_mode,
    input  logic [1:0]        rd_src_mode,
    input  logic [CODE_W-1:0] w2r_depth,
    input  logic [CODE_W-1:0] r2w_depth,
    output logic              wr_ptr_rst,
    output logic              rd_ptr_rst
);

    // Lane k serves the pointer of side k; its synchronizer brings the opposite reset in.
    logic [LANES-1:0]  lane_clk;
    logic [LANES-1:0]  lane_own;
    logic [LANES-1:0]  lane_peer;
    logic [LANES-1:0]  lane_sync;
    logic [LANES-1:0]  lane_ptr;
    logic [1:0]        lane_mode  [LANES];
    logic [CODE_W-1:0] lane_depth [LANES];

    assign lane_clk[LANE_RD]   = rd_clk;
    assign lane_own[LANE_RD]   = rd_rst_in;
    assign lane_peer[LANE_RD]  = wr_rst_in;
    assign lane_mode[LANE_RD]  = rd_src_mode;
    assign lane_depth[LANE_RD] = w2r_depth;

    assign lane_clk[LANE_WR]   = wr_clk;
    assign lane_own[LANE_WR]   = wr_rst_in;
    assign lane_peer[LANE_WR]  = rd_rst_in;
    assign lane_mode[LANE_WR]  = wr_src_mode;
    assign lane_depth[LANE_WR] = r2w_depth;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        rstc_sync_fsm #(
            .CODE_W     (CODE_W),
            .MIN_STAGES (MIN_STAGES)
        ) u_sync (
            .dst_clk    (lane_clk[k]),
            .src_rst    (lane_peer[k]),
            .depth_code (lane_depth[k]),
            .rst_out    (lane_sync[k])
        );

        rstc_src_sel u_sel (
            .mode      (lane_mode[k]),
            .own_rst   (lane_own[k]),
            .peer_sync (lane_sync[k]),
            .ptr_rst   (lane_ptr[k])
        );
    end

    assign rd_ptr_rst = lane_ptr[LANE_RD];
    assign wr_ptr_rst = lane_ptr[LANE_WR];

endmodule

// File: rtl/rstc_ptr_reset_chk.sv
`timescale 1ns/1ps
// Port-level properties of the pointer reset controller.
module rstc_ptr_reset_chk #(
    parameter int unsigned CODE_W = 2
) (
    input logic              wr_clk,
    input logic              rd_clk,
    input logic              wr_rst_in,
    input logic              rd_rst_in,
    input logic [1:0]        wr_src_mode,
    input logic [1:0]        rd_src_mode,
    input logic [CODE_W-1:0] w2r_depth,
    input logic [CODE_W-1:0] r2w_depth,
    input logic              wr_ptr_rst,
    input logic              rd_ptr_rst
);

    // R1: own-only mode, read pointer idle whenever its own reset is low
    a_r1_rd_ignores_peer: assert property (@(posedge rd_clk) disable iff (rd_rst_in)
        (!rd_src_mode[1]) |-> !rd_ptr_rst);

    // R2: own-only mode, write pointer idle whenever its own reset is low
    a_r2_wr_ignores_peer: assert property (@(posedge wr_clk) disable iff (wr_rst_in)
        (!wr_src_mode[1]) |-> !wr_ptr_rst);

    // R3: own reset still drives the read pointer outside the peer-only mode
    a_r3_rd_own_reset: assert property (@(posedge rd_clk) disable iff (wr_rst_in)
        (rd_src_mode != 2'b11 && rd_rst_in) |-> rd_ptr_rst);

    // R4: own reset still drives the write pointer outside the peer-only mode
    a_r4_wr_own_reset: assert property (@(posedge wr_clk) disable iff (rd_rst_in)
        (wr_src_mode != 2'b11 && wr_rst_in) |-> wr_ptr_rst);

    // R7: a present write reset is visible on the read pointer when crossing is selected
    a_r7_rd_follows_peer: assert property (@(posedge rd_clk) disable iff (rd_rst_in)
        (wr_rst_in && rd_src_mode[1]) |-> rd_ptr_rst);

    // R7: a present read reset is visible on the write pointer when crossing is selected
    a_r7_wr_follows_peer: assert property (@(posedge wr_clk) disable iff (wr_rst_in)
        (rd_rst_in && wr_src_mode[1]) |-> wr_ptr_rst);

    // R10: crossed write reset stays released while its source stays low
    a_r10_rd_stays_released: assert property (@(posedge rd_clk) disable iff (wr_rst_in)
        (rd_src_mode == 2'b11 && !rd_ptr_rst) |=> (rd_src_mode != 2'b11 || !rd_ptr_rst));

    // R10: crossed read reset stays released while its source stays low
    a_r10_wr_stays_released: assert property (@(posedge wr_clk) disable iff (rd_rst_in)
        (wr_src_mode == 2'b11 && !wr_ptr_rst) |=> (wr_src_mode != 2'b11 || !wr_ptr_rst));

endmodule

bind rstc_ptr_reset_ctrl rstc_ptr_reset_chk #(.CODE_W(CODE_W)) u_chk (
    .wr_clk      (wr_clk),
    .rd_clk      (rd_clk),
    .wr_rst_in   (wr_rst_in),
    .rd_rst_in   (rd_rst_in),
    .wr_src_mode (wr_src_mode),
    .rd_src_mode (rd_src_mode),
    .w2r_depth   (w2r_depth),
    .r2w_depth   (r2w_depth),
    .wr_ptr_rst  (wr_ptr_rst),
    .rd_ptr_rst  (rd_ptr_rst)
);

// File: tb/tb_rstc_ptr_reset_ctrl.sv
`timescale 1ns/1ps
module tb_rstc_ptr_reset_ctrl;

    localparam int WR_PERIOD = 10;
    localparam int RD_PERIOD = 14;
    localparam int MIN_ST    = 2;

    logic       wr_clk = 1'b0;
    logic       rd_clk = 1'b0;
    logic       wr_rst_in = 1'b0;
    logic       rd_rst_in = 1'b0;
    logic [1:0] wr_mode = 2'b00;
    logic [1:0] rd_mode = 2'b00;
    logic [1:0] w2r_depth = 2'b00;
    logic [1:0] r2w_depth = 2'b00;
    logic       wr_ptr_rst;
    logic       rd_ptr_rst;

    int vectors = 0;
    int miscompares = 0;
    bit chk_en = 1'b0;
    bit finished = 1'b0;

    rstc_ptr_reset_ctrl dut (
        .wr_clk      (wr_clk),
        .rd_clk      (rd_clk),
        .wr_rst_in   (wr_rst_in),
        .rd_rst_in   (rd_rst_in),
        .wr_src_mode (wr_mode),
        .rd_src_mode (rd_mode),
        .w2r_depth   (w2r_depth),
        .r2w_depth   (r2w_depth),
        .wr_ptr_rst  (wr_ptr_rst),
        .rd_ptr_rst  (rd_ptr_rst)
    );

    initial forever #(WR_PERIOD / 2) wr_clk = ~wr_clk;
    initial begin
        #0.3;
        forever #(RD_PERIOD / 2) rd_clk = ~rd_clk;
    end

    // Reference model: destination edges seen since each source reset was last low
    int w2r_edges = 0;
    int r2w_edges = 0;

    always @(posedge rd_clk or posedge wr_rst_in) begin
        if (wr_rst_in) w2r_edges = 0;
        else if (w2r_edges < 16) w2r_edges = w2r_edges + 1;
    end

    always @(posedge wr_clk or posedge rd_rst_in) begin
        if (rd_rst_in) r2w_edges = 0;
        else if (r2w_edges < 16) r2w_edges = r2w_edges + 1;
    end

    function automatic logic ref_ptr(logic [1:0] m, logic own, logic peer);
        case (m)
            2'b10:   return own | peer;
            2'b11:   return peer;
            default: return own;
        endcase
    endfunction

    function automatic string rd_tag(logic [1:0] m);
        case (m)
            2'b10:   return "R3";
            2'b11:   return "R5";
            default: return "R1";
        endcase
    endfunction

    function automatic string wr_tag(logic [1:0] m);
        case (m)
            2'b10:   return "R4";
            2'b11:   return "R6";
            default: return "R2";
        endcase
    endfunction

    task automatic check_bit(string tag, string what, logic got, logic exp);
        vectors++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s %s: got %b expected %b at %0t", tag, what, got, exp, $time);
        end
    endtask

    task automatic check_int(string tag, string what, int got, int exp);
        vectors++;
        if (got != exp) begin
            miscompares++;
            $display("FAIL %s %s: got %0d expected %0d at %0t", tag, what, got, exp, $time);
        end
    endtask

    // Per-cycle comparison; covers the crossed-reset release and hold (R8, R9, R10)
    always @(negedge rd_clk) begin
        if (chk_en) begin
            logic w2r_ref;
            w2r_ref = wr_rst_in || (w2r_edges < MIN_ST + int'(w2r_depth));
            check_bit(rd_tag(rd_mode), "rd_ptr_rst per-cycle", rd_ptr_rst,
                      ref_ptr(rd_mode, rd_rst_in, w2r_ref));
        end
    end

    always @(negedge wr_clk) begin
        if (chk_en) begin
            logic r2w_ref;
            r2w_ref = rd_rst_in || (r2w_edges < MIN_ST + int'(r2w_depth));
            check_bit(wr_tag(wr_mode), "wr_ptr_rst per-cycle", wr_ptr_rst,
                      ref_ptr(wr_mode, wr_rst_in, r2w_ref));
        end
    end

    task automatic wr_set(logic v);
        @(posedge wr_clk);
        #1;
        wr_rst_in = v;
    endtask

    task automatic rd_set(logic v);
        @(posedge rd_clk);
        #1;
        rd_rst_in = v;
    endtask

    task automatic run_combo(logic [1:0] wm, logic [1:0] rm, logic [1:0] wd, logic [1:0] rdp);
        wr_set(1'b1);
        rd_set(1'b1);
        @(posedge wr_clk);
        #1;
        wr_mode   = wm;
        rd_mode   = rm;
        w2r_depth = wd;
        r2w_depth = rdp;
        repeat (3) @(posedge wr_clk);
        wr_set(1'b0);
        rd_set(1'b0);
        repeat (8) @(posedge rd_clk);
        // Write reset alone: ignored by own-only read mode (R1), crosses otherwise
        wr_set(1'b1);
        repeat (3) @(posedge wr_clk);
        wr_set(1'b0);
        repeat (8) @(posedge rd_clk);
        // Read reset alone: ignored by peer-only read mode (R5)
        rd_set(1'b1);
        repeat (3) @(posedge rd_clk);
        rd_set(1'b0);
        repeat (8) @(posedge rd_clk);
    endtask

    task automatic timing_probe(int d);
        int n;
        wr_set(1'b1);
        rd_set(1'b1);
        @(posedge wr_clk);
        #1;
        wr_mode   = 2'b11;
        rd_mode   = 2'b11;
        w2r_depth = d[1:0];
        r2w_depth = d[1:0];
        repeat (3) @(posedge wr_clk);
        wr_set(1'b0);
        rd_set(1'b0);
        repeat (8) @(posedge rd_clk);

        // R7: read pointer reset rises between read clock edges
        @(posedge wr_clk);
        #1;
        wr_rst_in = 1'b1;
        #0.2;
        check_bit("R7", "rd_ptr_rst immediate rise", rd_ptr_rst, 1'b1);
        repeat (3) @(posedge wr_clk);
        #1;
        wr_rst_in = 1'b0;
        n = 0;
        while (n < 12) begin
            @(posedge rd_clk);
            n++;
            #1;
            if (!rd_ptr_rst) break;
        end
        check_int("R8", "read-side release edge count", n, MIN_ST + d);

        // R7: write pointer reset rises between write clock edges
        @(posedge rd_clk);
        #1;
        rd_rst_in = 1'b1;
        #0.2;
        check_bit("R7", "wr_ptr_rst immediate rise", wr_ptr_rst, 1'b1);
        repeat (3) @(posedge rd_clk);
        #1;
        rd_rst_in = 1'b0;
        n = 0;
        while (n < 12) begin
            @(posedge wr_clk);
            n++;
            #1;
            if (!wr_ptr_rst) break;
        end
        check_int("R9", "write-side release edge count", n, MIN_ST + d);
        repeat (4) @(posedge rd_clk);
    endtask

    initial begin
        #1;
        wr_rst_in = 1'b1;
        rd_rst_in = 1'b1;
        #2;
        // Reset state: both pointers held
        check_bit("R1", "rd_ptr_rst after reset", rd_ptr_rst, 1'b1);
        check_bit("R2", "wr_ptr_rst after reset", wr_ptr_rst, 1'b1);
        chk_en = 1'b1;

        for (int d = 0; d < 4; d++) begin
            for (int m = 0; m < 16; m++) begin
                run_combo(m[3:2], m[1:0], d[1:0], 2'(3 - d));
            end
        end

        for (int d = 0; d < 4; d++) begin
            timing_probe(d);
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #500000;
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog (all requirements): got timeout expected completion at %0t", $time);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule